// File: doc/BRIEF.md
# Overlapped Event Load/Readout Sequencer

This block paces a pattern-matching pipeline in which the hits of one event are loaded while the results of the previous event are still being read out. Two state machines work side by side. The loader waits for the end-of-event marker of the incoming hit stream. The readout machine drives the result-sending enable until the result stream reports its own end-of-event, and then observes a programmable settling delay.

A new event is launched only when the loader has seen its end-of-event and the readout machine is idle and ready. At launch the block pulses an event-init strobe to the pattern engines and latches the event identifier. The readout machine starts sending the results of the event just loaded. The loader then waits a programmable number of cycles before it accepts the next event's hits.

Each end-of-event input can be masked, so that it counts as always present. A global init returns both machines to idle, and the combined state is exported as a 4-bit code.

Top module: `event_overlap_seq`

## Requirements
- R1: While `rst` or `glob_init` is high, both machines are idle, `fsm_code` is 0, `send_en` and `evt_init` are 0. `glob_init` leaves `evt_id` unchanged, and `rst` clears it to 0.
- R2: `fsm_code[1:0]` is the loader state (0 idle, 1 loading, 2 done) and `fsm_code[3:2]` is the readout state (0 idle, 1 ready, 2 sending, 3 holding). One cycle after `glob_init` falls, the code reads 4'b0101.
- R3: A hit end-of-event seen while loading is remembered. Launch happens only once one has been seen (in that cycle or earlier in the loading state) and the readout machine is ready.
- R4: `evt_init` is a one-cycle pulse, high in the first cycle of the loader's done state.
- R5: At launch `evt_id` takes the identifier of the end-of-event that satisfied the loader, and it holds its value at all other times.
- R6: The readout machine enters sending in the same cycle that the loader enters done. `send_en` is high exactly while sending.
- R7: The loader stays in done for `hit_wait + 1` cycles, then returns to loading.
- R8: A road end-of-event while sending moves the readout machine to holding for `road_wait + 1` cycles, after which it returns to ready.
- R9: With `eoe_mask[0]` set, the hit end-of-event counts as always present. A launch without a new marker keeps the last captured identifier.
- R10: With `eoe_mask[1]` set, the road end-of-event counts as always present, so sending lasts one cycle.
- R11: A hit end-of-event that arrives while the loader is not in the loading state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_init | input | 1 | Global init; holds both machines idle |
| hit_eoe | input | 1 | Hit end-of-event strobe |
| hit_eoe_id | input | ID_W | Event identifier carried with `hit_eoe` |
| road_eoe | input | 1 | Road end-of-event strobe |
| hit_wait | input | CNT_W | Extra cycles in the loader done state |
| road_wait | input | CNT_W | Extra cycles in the readout holding state |
| eoe_mask | input | 2 | Bit 0 masks the hit marker, bit 1 masks the road marker |
| evt_init | output | 1 | Event-init pulse to the pattern engines |
| send_en | output | 1 | Result-sending enable |
| evt_id | output | ID_W | Identifier of the current event |
| fsm_code | output | 4 | Combined state code |

## Verification
The hardest case to reach is a hit end-of-event that arrives while the readout of the previous event is still running, because it must be held back and launched later. The stimulus gets there by sending the second marker before the road marker, checking that nothing launches and that the identifier is unchanged, and then releasing the readout. A marker sent while the loader sits in its done window is also driven. The bench checks that this marker never produces a launch, even after both machines are back at ready.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_LOAD = 2'd1,
    HS_DONE = 2'd2
  } hit_st_t;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_READY = 2'd1,
    RS_SEND  = 2'd2,
    RS_HOLD  = 2'd3
  } road_st_t;
endpackage

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/hit_fsm.sv
module hit_fsm
  import seq_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_init,
  input  logic             eoe,
  input  logic [ID_W-1:0]  eoe_id,
  input  logic             eoe_masked,
  input  logic             road_ready,
  input  logic [CNT_W-1:0] wait_cfg,
  output logic             launch,
  output hit_st_t          state,
  output logic             evt_init,
  output logic [ID_W-1:0]  evt_id
);
  hit_st_t         nxt;
  logic            seen;
  logic [ID_W-1:0] pend_id;
  logic            expired;

  assign launch = (state == HS_LOAD) && (eoe || seen || eoe_masked) && road_ready && !glob_init;

  hold_timer #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .load(launch), .load_val(wait_cfg),
    .run(state == HS_DONE), .expired(expired)
  );

  always_comb begin
    nxt = state;
    if (glob_init) nxt = HS_IDLE;
    else begin
      case (state)
        HS_IDLE: nxt = HS_LOAD;
        HS_LOAD: if (launch) nxt = HS_DONE;
        HS_DONE: if (expired) nxt = HS_LOAD;
        default: nxt = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= HS_IDLE;
      seen     <= 1'b0;
      pend_id  <= '0;
      evt_init <= 1'b0;
      evt_id   <= '0;
    end else begin
      state    <= nxt;
      evt_init <= launch;
      if (launch) evt_id <= eoe ? eoe_id : pend_id;
      if (glob_init || launch)        seen <= 1'b0;
      else if (state == HS_LOAD && eoe) seen <= 1'b1;
      if (state == HS_LOAD && eoe) pend_id <= eoe_id;
    end
  end

  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    evt_init |=> !evt_init);                                   // R4
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == HS_DONE) |=> (state != HS_IDLE || $past(glob_init)) && state != HS_LOAD || $past(expired)); // R7
  AST_ID_HELD: assert property (@(posedge clk) disable iff (rst)
    !evt_init |-> $stable(evt_id));                            // R5
endmodule

// File: rtl/road_fsm.sv
module road_fsm
  import seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_init,
  input  logic             launch,
  input  logic             eoe,
  input  logic             eoe_masked,
  input  logic [CNT_W-1:0] wait_cfg,
  output road_st_t         state,
  output logic             send_en
);
  road_st_t nxt;
  logic     expired;
  logic     finish;

  assign finish = (state == RS_SEND) && (eoe || eoe_masked);

  hold_timer #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .load(finish), .load_val(wait_cfg),
    .run(state == RS_HOLD), .expired(expired)
  );

  always_comb begin
    nxt = state;
    if (glob_init) nxt = RS_IDLE;
    else begin
      case (state)
        RS_IDLE:  nxt = RS_READY;
        RS_READY: if (launch) nxt = RS_SEND;
        RS_SEND:  if (finish) nxt = RS_HOLD;
        RS_HOLD:  if (expired) nxt = RS_READY;
        default:  nxt = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RS_IDLE;
      send_en <= 1'b0;
    end else begin
      state   <= nxt;
      send_en <= (nxt == RS_SEND);
    end
  end

  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == RS_HOLD) |=> state != RS_SEND);                  // R8
  AST_SEND_ONLY_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(send_en) |-> $past(state) == RS_READY);              // R6
endmodule

// File: rtl/event_overlap_seq.sv
module event_overlap_seq
  import seq_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_init,
  input  logic             hit_eoe,
  input  logic [ID_W-1:0]  hit_eoe_id,
  input  logic             road_eoe,
  input  logic [CNT_W-1:0] hit_wait,
  input  logic [CNT_W-1:0] road_wait,
  input  logic [1:0]       eoe_mask,
  output logic             evt_init,
  output logic             send_en,
  output logic [ID_W-1:0]  evt_id,
  output logic [3:0]       fsm_code
);
  localparam int MASK_HIT  = 0;
  localparam int MASK_ROAD = 1;

  hit_st_t  hit_state;
  road_st_t road_state;
  logic     launch;

  hit_fsm #(.ID_W(ID_W), .CNT_W(CNT_W)) u_hit (
    .clk(clk), .rst(rst), .glob_init(glob_init),
    .eoe(hit_eoe), .eoe_id(hit_eoe_id), .eoe_masked(eoe_mask[MASK_HIT]),
    .road_ready(road_state == RS_READY), .wait_cfg(hit_wait),
    .launch(launch), .state(hit_state), .evt_init(evt_init), .evt_id(evt_id)
  );

  road_fsm #(.CNT_W(CNT_W)) u_road (
    .clk(clk), .rst(rst), .glob_init(glob_init), .launch(launch),
    .eoe(road_eoe), .eoe_masked(eoe_mask[MASK_ROAD]), .wait_cfg(road_wait),
    .state(road_state), .send_en(send_en)
  );

  assign fsm_code = {road_state, hit_state};

  AST_INIT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    glob_init |=> fsm_code == 4'd0 && !send_en);               // R1
  AST_LAUNCH_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    evt_init |-> $past(road_state) == RS_READY);               // R3
  AST_SEND_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(send_en) |-> hit_state == HS_DONE && evt_init);      // R6
endmodule

// File: tb/test_event_overlap_seq.sv
module test_event_overlap_seq;
  localparam int ID_W  = 16;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             glob_init;
  logic             hit_eoe;
  logic [ID_W-1:0]  hit_eoe_id;
  logic             road_eoe;
  logic [CNT_W-1:0] hit_wait;
  logic [CNT_W-1:0] road_wait;
  logic [1:0]       eoe_mask;
  logic             evt_init;
  logic             send_en;
  logic [ID_W-1:0]  evt_id;
  logic [3:0]       fsm_code;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  event_overlap_seq #(.ID_W(ID_W), .CNT_W(CNT_W)) i_event_overlap_seq (
    .clk(clk), .rst(rst), .glob_init(glob_init), .hit_eoe(hit_eoe),
    .hit_eoe_id(hit_eoe_id), .road_eoe(road_eoe), .hit_wait(hit_wait),
    .road_wait(road_wait), .eoe_mask(eoe_mask), .evt_init(evt_init),
    .send_en(send_en), .evt_id(evt_id), .fsm_code(fsm_code)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int code, input int init, input int snd, input int id);
    chk({req, " fsm_code"}, fsm_code, code);
    chk({req, " evt_init"}, evt_init, init);
    chk({req, " send_en"},  send_en,  snd);
    chk({req, " evt_id"},   evt_id,   id);
  endtask

  task automatic t_reset();
    rst = 1'b1; glob_init = 1'b1; hit_eoe = 1'b0; hit_eoe_id = '0;
    road_eoe = 1'b0; hit_wait = 8'd2; road_wait = 8'd1; eoe_mask = 2'b00;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk_out("R1 reset", 0, 0, 0, 0);
    glob_init = 1'b0;
    step();
    chk_out("R2 release", 4'h5, 0, 0, 0);
  endtask

  // first event launches immediately: road already ready
  task automatic t_first_event();
    hit_eoe = 1'b1; hit_eoe_id = 16'h005A;
    step();
    hit_eoe = 1'b0;
    chk_out("R4 R5 R6 launch", 4'hA, 1, 1, 16'h005A);
    step();
    chk_out("R4 pulse ends", 4'hA, 0, 1, 16'h005A);
    step();
    chk("R7 still done", fsm_code, 4'hA);
    step();
    chk("R7 back to load", fsm_code, 4'h9);
  endtask

  // second marker arrives while readout still busy: must wait
  task automatic t_overlap();
    hit_eoe = 1'b1; hit_eoe_id = 16'h0033;
    step();
    hit_eoe = 1'b0;
    chk_out("R3 held off", 4'h9, 0, 1, 16'h005A);
    step(); step();
    chk_out("R3 still held", 4'h9, 0, 1, 16'h005A);
    road_eoe = 1'b1;
    step();
    road_eoe = 1'b0;
    chk_out("R8 hold entered", 4'hD, 0, 0, 16'h005A);
    step();
    chk("R8 hold second cycle", fsm_code, 4'hD);
    step();
    chk_out("R8 ready again", 4'h5, 0, 0, 16'h005A);
    step();
    chk_out("R3 R5 deferred launch", 4'hA, 1, 1, 16'h0033);
  endtask

  task automatic t_masks();
    eoe_mask = 2'b10;
    step();
    chk_out("R10 send one cycle", 4'hE, 0, 0, 16'h0033);
    step();
    chk("R10 hold", fsm_code, 4'hE);
    step();
    chk("R10 ready", fsm_code, 4'h5);
    eoe_mask = 2'b01;
    step();
    chk_out("R9 masked launch", 4'hA, 1, 1, 16'h0033);
  endtask

  task automatic t_glob_init();
    eoe_mask = 2'b00; glob_init = 1'b1;
    step();
    chk_out("R1 init mid-run", 0, 0, 0, 16'h0033);
    step();
    chk("R1 init held", fsm_code, 0);
    glob_init = 1'b0;
    step();
    chk("R2 release again", fsm_code, 4'h5);
  endtask

  // marker during the done window must be dropped
  task automatic t_ignored();
    hit_eoe = 1'b1; hit_eoe_id = 16'h0011;
    step();
    chk_out("R5 launch 11", 4'hA, 1, 1, 16'h0011);
    hit_eoe_id = 16'h0077;
    step();
    hit_eoe = 1'b0; road_eoe = 1'b1;
    step();
    road_eoe = 1'b0;
    repeat (5) step();
    chk_out("R11 marker in done ignored", 4'h5, 0, 0, 16'h0011);
    hit_eoe = 1'b1; hit_eoe_id = 16'h0044;
    step();
    hit_eoe = 1'b0;
    chk_out("R11 fresh marker launches", 4'hA, 1, 1, 16'h0044);
  endtask

  initial begin
    t_reset();
    t_first_event();
    t_overlap();
    t_masks();
    t_glob_init();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule